// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter

This block sequences service for four DMA channels that share one memory port. Each channel has an active-low request line that may change at any time relative to the clock. The block picks one channel at a time, using either a fixed or a rotating priority order, and raises a single bus request toward the memory port. While that channel's access is open, the channel's active-low acknowledge is driven. The memory side answers each access with a one-cycle done pulse, and every done pulse takes a fixed transfer size off the serviced channel's byte count.

Each channel has one shared end-of-process / terminal-count function. A configuration bit selects its direction. As an input, a falling edge ends the channel's current buffer. As an output, the terminal-count line is driven low together with the acknowledge during the buffer's final access. With chaining enabled, the end of a buffer, whether it comes from the count or from an end-of-process edge, loads a second count register prepared beforehand. That register is then cleared. Byte counts are written through a simple write strobe with a channel select and a current/next select.

Top module: `dmaArbiter`

## Requirements
- R1: After reset, all acknowledge lines and all terminal-count lines are high (inactive), the bus request is low, and the terminal-count drive enables equal the per-channel output-mode configuration bits.
- R2: Once a channel is granted, the bus request stays high with the channel number on busChan, and only that channel's acknowledge line is low, until the cycle in which busDone is sampled high. The request then drops for at least one cycle.
- R3: With prioRotate low, simultaneous eligible requests are served lowest channel number first, and a channel keeps winning while it stays eligible.
- R4: With prioRotate high, the search starts at the channel after the one served last (channel 0 first after reset), so the channel just served becomes lowest.
- R5: A channel whose enable bit is low, or whose byte count is zero, is never granted, even while its request line is low.
- R6: Each completed access lowers the served channel's count by XFER_BYTES. When the count reaches zero, the channel stops being served (count 12 with transfer size 4 gives exactly three accesses).
- R7: For a channel in output mode (pinOut bit 1), tcN of that channel is low exactly while its acknowledge is low during an access that starts with a count of XFER_BYTES or less. tcDrive equals pinOut.
- R8: For a channel in input mode, without chaining, a falling edge on its eopN sets its count to zero. Holding eopN low terminates only once, so a count written afterwards is served normally.
- R9: For a channel in input mode with chaining, an eopN falling edge loads the next-buffer count into the count and clears the next-buffer count.
- R10: eopN of a channel in output mode has no effect on that channel's count.
- R11: An eopN edge that arrives during that channel's open access takes effect when the access completes, and that access's decrement is discarded.
- R12: With chaining, a count that reaches zero through completed accesses is reloaded from the next-buffer count, which is then cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqN | input | 4 | Asynchronous active-low channel requests |
| eopN | input | 4 | Asynchronous active-low end-of-process inputs |
| tcN | output | 4 | Active-low terminal-count outputs |
| tcDrive | output | 4 | Drive enable for the terminal-count output of each channel |
| ackN | output | 4 | Active-low per-channel acknowledge |
| chEn | input | 4 | Channel enables |
| chainMode | input | 4 | Per-channel buffer chaining enable |
| pinOut | input | 4 | 1 = terminal-count output, 0 = end-of-process input |
| prioRotate | input | 1 | 0 = fixed priority, 1 = rotating priority |
| cfgWe | input | 1 | Count register write strobe |
| cfgChan | input | 2 | Channel selected for the write |
| cfgNext | input | 1 | 0 = write current count, 1 = write next-buffer count |
| cfgData | input | CNT_W | Byte count value to write |
| busReq | output | 1 | Access request toward the memory port |
| busChan | output | 2 | Channel owning the open access |
| busDone | input | 1 | Access completion pulse |

## Verification
The collision that matters is an end-of-process edge on a channel that meets the completion of that same channel's access. Both want to change the channel's count in the same cycle. The bench provokes it by holding an access open for ten cycles and pulsing eopN inside that window, once on a plain channel and once on a chaining channel. It judges the outcome only by the number of later grants: zero for the plain channel, and exactly the full next-buffer count divided by the transfer size for the chaining channel. A leftover decrement would show up as one grant too few.

// File: rtl/dmaArbPkg.sv
package dmaArbPkg;
  localparam int NCH = 4;
  localparam int CHW = $clog2(NCH);

  typedef struct packed {
    logic           busy;
    logic           done;
    logic [CHW-1:0] chan;
  } arbStrobe_t;
endpackage

// File: rtl/dmaSync.sv
module dmaSync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);
  logic [W-1:0] stage1;

  // Inputs are active low, so the reset value is all ones (idle).
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1  <= '1;
      syncOut <= '1;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end
endmodule

// File: rtl/dmaArbCtrl.sv
module dmaArbCtrl
  import dmaArbPkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic [NCH-1:0] want,
  input  logic           prioRotate,
  input  logic           busDone,
  output arbStrobe_t     strb
);
  logic           busy;
  logic [CHW-1:0] chan;
  logic [CHW-1:0] lastCh;
  logic           found;
  logic [CHW-1:0] winner;
  logic [CHW-1:0] idx;

  // Search order: from 0 upward (fixed) or from the slot after the last winner.
  always_comb begin
    found  = 1'b0;
    winner = '0;
    idx    = '0;
    for (int i = 0; i < NCH; i++) begin
      idx = prioRotate ? CHW'(lastCh + CHW'(1) + CHW'(i)) : CHW'(i);
      if (!found && want[idx]) begin
        found  = 1'b1;
        winner = idx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      chan   <= '0;
      lastCh <= CHW'(NCH - 1);
    end else if (busy) begin
      if (busDone) busy <= 1'b0;
    end else if (found) begin
      busy   <= 1'b1;
      chan   <= winner;
      lastCh <= winner;
    end
  end

  assign strb.busy = busy;
  assign strb.done = busy & busDone;
  assign strb.chan = chan;
endmodule

// File: rtl/dmaArbPath.sv
module dmaArbPath
  import dmaArbPkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int XFER_BYTES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  arbStrobe_t       strb,
  input  logic [NCH-1:0]   eopAct,
  input  logic [NCH-1:0]   chEn,
  input  logic [NCH-1:0]   chainMode,
  input  logic [NCH-1:0]   pinOut,
  input  logic             cfgWe,
  input  logic [CHW-1:0]   cfgChan,
  input  logic             cfgNext,
  input  logic [CNT_W-1:0] cfgData,
  output logic [NCH-1:0]   eligible,
  output logic [NCH-1:0]   ackN,
  output logic [NCH-1:0]   tcN
);
  localparam logic [CNT_W-1:0] XFER = CNT_W'(XFER_BYTES);

  for (genvar g = 0; g < NCH; g++) begin : gChan
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] nxt;
    logic             eopPrev;
    logic             eopPend;
    logic             mine;
    logic             eopEdge;
    logic             termReq;
    logic             termNow;
    logic             lastDone;
    logic             bufEnd;
    logic             wrCur;
    logic             wrNxt;

    assign mine     = strb.busy && (strb.chan == CHW'(g));
    assign eopEdge  = eopAct[g] & ~eopPrev & ~pinOut[g];
    assign termReq  = eopEdge | eopPend;
    // A termination waits while this channel's access is still open.
    assign termNow  = termReq & ~(mine & ~strb.done);
    assign lastDone = mine & strb.done & (cnt <= XFER) & ~termNow;
    assign bufEnd   = termNow | lastDone;
    assign wrCur    = cfgWe && (cfgChan == CHW'(g)) && !cfgNext;
    assign wrNxt    = cfgWe && (cfgChan == CHW'(g)) && cfgNext;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cnt     <= '0;
        nxt     <= '0;
        eopPrev <= 1'b0;
        eopPend <= 1'b0;
      end else begin
        eopPrev <= eopAct[g];
        eopPend <= termReq & ~termNow;
        if (wrCur)                   cnt <= cfgData;
        else if (bufEnd)             cnt <= chainMode[g] ? nxt : '0;
        else if (mine && strb.done)  cnt <= cnt - XFER;
        if (wrNxt)                           nxt <= cfgData;
        else if (bufEnd && chainMode[g])     nxt <= '0;
      end
    end

    assign eligible[g] = chEn[g] & (cnt != '0) & ~termReq;
    assign ackN[g]     = ~mine;
    assign tcN[g]      = ~(mine & pinOut[g] & (cnt != '0) & (cnt <= XFER));
  end
endmodule

// File: rtl/dmaArbiter.sv
module dmaArbiter
  import dmaArbPkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int XFER_BYTES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       reqN,
  input  logic [3:0]       eopN,
  output logic [3:0]       tcN,
  output logic [3:0]       tcDrive,
  output logic [3:0]       ackN,
  input  logic [3:0]       chEn,
  input  logic [3:0]       chainMode,
  input  logic [3:0]       pinOut,
  input  logic             prioRotate,
  input  logic             cfgWe,
  input  logic [1:0]       cfgChan,
  input  logic             cfgNext,
  input  logic [CNT_W-1:0] cfgData,
  output logic             busReq,
  output logic [1:0]       busChan,
  input  logic             busDone
);
  logic [2*NCH-1:0] syncN;
  logic [NCH-1:0]   reqAct;
  logic [NCH-1:0]   eopAct;
  logic [NCH-1:0]   eligible;
  arbStrobe_t       strb;

  dmaSync #(.W(2 * NCH)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({eopN, reqN}),
    .syncOut (syncN)
  );

  assign reqAct = ~syncN[NCH-1:0];
  assign eopAct = ~syncN[2*NCH-1:NCH];

  dmaArbCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .want       (reqAct & eligible),
    .prioRotate (prioRotate),
    .busDone    (busDone),
    .strb       (strb)
  );

  dmaArbPath #(.CNT_W(CNT_W), .XFER_BYTES(XFER_BYTES)) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .eopAct    (eopAct),
    .chEn      (chEn),
    .chainMode (chainMode),
    .pinOut    (pinOut),
    .cfgWe     (cfgWe),
    .cfgChan   (cfgChan),
    .cfgNext   (cfgNext),
    .cfgData   (cfgData),
    .eligible  (eligible),
    .ackN      (ackN),
    .tcN       (tcN)
  );

  assign busReq  = strb.busy;
  assign busChan = strb.chan;
  assign tcDrive = pinOut;
endmodule

// File: rtl/dmaArbiterChk.sv
module dmaArbiterChk (
  input logic       clk,
  input logic       rstN,
  input logic       busReq,
  input logic [1:0] busChan,
  input logic       busDone,
  input logic [3:0] ackN,
  input logic [3:0] tcN,
  input logic [3:0] tcDrive
);
  assert_ack_follows_grant_R2: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> ((~ackN) == (4'b0001 << busChan)));

  assert_ack_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !busReq |-> (ackN == 4'hF));

  assert_grant_held_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busDone) |=> (busReq && $stable(busChan)));

  assert_release_after_done_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busDone) |=> !busReq);

  assert_tc_inside_ack_R7: assert property (@(posedge clk) disable iff (!rstN)
    (((~tcN) & ackN) == 4'h0) && (((~tcN) & ~tcDrive) == 4'h0));

  assert_tc_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busDone) |=> $stable(tcN));
endmodule

bind dmaArbiter dmaArbiterChk u_chk (.*);

// File: tb/dmaArbiter_bench.sv
module dmaArbiter_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [3:0]  reqN, eopN, tcN, tcDrive, ackN, chEn, chainMode, pinOut;
  logic        prioRotate, cfgWe, cfgNext, busReq, busDone;
  logic [1:0]  cfgChan, busChan;
  logic [15:0] cfgData;

  typedef struct {
    int    ch;
    bit    tc;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int  passCnt = 0;
  int  failCnt = 0;
  int  doneDelay = 2;
  bit  inAccess = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dmaArbiter u_dmaArbiter (.*);

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    if (ok) passCnt++;
    else begin
      failCnt++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Monitor and memory-side responder: compares each new grant with the queue head.
  initial begin
    expItem_t e;
    logic [3:0] oneHot;
    busDone = 1'b0;
    forever begin
      @(negedge clk);
      if (busReq) begin
        inAccess = 1'b1;
        if (expQ.size() == 0) begin
          check(1'b0, "R5", "unexpected grant on channel", busChan, -1);
        end else begin
          e = expQ.pop_front();
          oneHot = 4'b0001 << e.ch;
          check(busChan == e.ch[1:0], e.tag, "granted channel", busChan, e.ch);
          check(ackN == ~oneHot, e.tag, "ackN", ackN, ~oneHot);
          check(tcN == (e.tc ? ~oneHot : 4'hF), e.tag, "tcN", tcN,
                e.tc ? ~oneHot : 4'hF);
        end
        repeat (doneDelay) @(negedge clk);
        busDone = 1'b1;
        @(negedge clk);
        busDone = 1'b0;
        inAccess = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R2", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
    $finish;
  end

  task automatic pushItem(input int ch, input bit tc, input string tag);
    expItem_t e;
    e.ch = ch; e.tc = tc; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic pushRun(input int ch, input int n, input bit tcLast, input string tag);
    for (int i = 0; i < n; i++) pushItem(ch, tcLast && (i == n - 1), tag);
  endtask

  task automatic drain(input string tag);
    while (expQ.size() != 0 || inAccess) @(negedge clk);
    repeat (12) @(negedge clk);
    check(!busReq && expQ.size() == 0, tag, "no further grant", busReq, 0);
  endtask

  task automatic cfgSet(input int ch, input bit nextSel, input int val);
    @(negedge clk);
    cfgWe = 1'b1; cfgChan = ch[1:0]; cfgNext = nextSel; cfgData = val[15:0];
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic eopPulse(input int ch);
    @(negedge clk);
    eopN[ch] = 1'b0;
    repeat (3) @(negedge clk);
    eopN[ch] = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    rstN = 1'b0; reqN = 4'hF; eopN = 4'hF; chEn = 4'hF; chainMode = 4'h0;
    pinOut = 4'h0; prioRotate = 1'b0; cfgWe = 1'b0; cfgChan = 2'd0;
    cfgNext = 1'b0; cfgData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(ackN == 4'hF, "R1", "ackN after reset", ackN, 15);
    check(!busReq, "R1", "busReq after reset", busReq, 0);
    check(tcN == 4'hF, "R1", "tcN after reset", tcN, 15);
    check(tcDrive == pinOut, "R1", "tcDrive after reset", tcDrive, pinOut);

    // R2 R6 R7: single channel, count 12 -> three accesses, TC on the last
    pinOut = 4'b0100;
    @(negedge clk);
    check(tcDrive == 4'b0100, "R7", "tcDrive follows pinOut", tcDrive, 4);
    cfgSet(2, 0, 12);
    pushRun(2, 3, 1'b1, "R6");
    reqN = 4'b1011;
    drain("R6");
    reqN = 4'hF;
    pinOut = 4'h0;

    // R3 fixed priority
    cfgSet(0, 0, 8); cfgSet(1, 0, 8); cfgSet(3, 0, 8);
    pushRun(0, 2, 0, "R3"); pushRun(1, 2, 0, "R3"); pushRun(3, 2, 0, "R3");
    reqN = 4'b0100;
    drain("R3");
    reqN = 4'hF;

    // R4 rotating priority
    prioRotate = 1'b1;
    cfgSet(0, 0, 8); cfgSet(1, 0, 8); cfgSet(3, 0, 8);
    for (int k = 0; k < 2; k++) begin
      pushItem(0, 0, "R4"); pushItem(1, 0, "R4"); pushItem(3, 0, "R4");
    end
    reqN = 4'b0100;
    drain("R4");
    reqN = 4'hF;
    prioRotate = 1'b0;

    // R5 disabled channel and zero-count channel are masked
    chEn = 4'b1101;
    cfgSet(1, 0, 8);
    reqN = 4'b1100;
    drain("R5");
    pushRun(1, 2, 0, "R5");
    chEn = 4'hF;
    drain("R5");
    reqN = 4'hF;

    // R8 end-of-process input, held low: terminates once
    cfgSet(0, 0, 40);
    eopN[0] = 1'b0;
    repeat (6) @(negedge clk);
    reqN[0] = 1'b0;
    drain("R8");
    cfgSet(0, 0, 8);
    pushRun(0, 2, 0, "R8");
    drain("R8");
    reqN = 4'hF;
    eopN[0] = 1'b1;

    // R9 chaining: end-of-process loads next-buffer count
    chainMode = 4'b0010;
    cfgSet(1, 0, 40); cfgSet(1, 1, 8);
    eopPulse(1);
    pushRun(1, 2, 0, "R9");
    reqN[1] = 1'b0;
    drain("R9");
    reqN = 4'hF;

    // R10 end-of-process ignored in output mode
    pinOut = 4'b1000;
    cfgSet(3, 0, 8);
    eopPulse(3);
    pushRun(3, 2, 1'b1, "R10");
    reqN[3] = 1'b0;
    drain("R10");
    reqN = 4'hF;
    pinOut = 4'h0;

    // R11 end-of-process during an open access, plain channel
    doneDelay = 10;
    cfgSet(0, 0, 40);
    pushItem(0, 0, "R11");
    reqN[0] = 1'b0;
    while (!busReq) @(negedge clk);
    eopPulse(0);
    drain("R11");
    reqN = 4'hF;

    // R11 same collision on a chaining channel: full next buffer survives
    cfgSet(1, 0, 40); cfgSet(1, 1, 8);
    pushRun(1, 3, 0, "R11");
    reqN[1] = 1'b0;
    while (!busReq) @(negedge clk);
    eopPulse(1);
    drain("R11");
    reqN = 4'hF;
    doneDelay = 2;

    // R12 count exhaustion with chaining reloads next buffer
    chainMode = 4'b0100;
    pinOut = 4'b0100;
    cfgSet(2, 0, 4); cfgSet(2, 1, 8);
    pushItem(2, 1, "R12"); pushItem(2, 0, "R12"); pushItem(2, 1, "R12");
    reqN[2] = 1'b0;
    drain("R12");
    reqN = 4'hF;

    $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
    $finish;
  end
endmodule